// File: doc/BRIEF.md
# JTAG Test Access Port with User-Code Readout

This block is a test access port controller for a boundary-scan chain. It is clocked by the test clock and moves through the sixteen standard controller states under the mode-select input. A four-bit instruction register chooses the serial path between `tdi` and `tdo`. The path can be a one-bit bypass stage, a 32-bit identification stage that returns the user code, or a boundary register over `PINS` user output pins. Each pin has a value cell and an enable cell. The instructions are bypass, user-code readout, sample, external test, clamp and high-impedance. Clamp and high-impedance fix the pin drive and route the serial path through bypass.

The user code is held in two copies. System logic writes a pending copy, which stands for the non-volatile value. Readout always returns the running copy. A reload strobe copies the pending copy into the running copy, and it stands for a power cycle or a forced download. When the configured flag `cfg_done` is low, readout returns all ones in place of the code.

Controller states and transitions (next state for mode-select 0 / 1): Test-Logic-Reset → Run-Test-Idle / Test-Logic-Reset. Run-Test-Idle → Run-Test-Idle / Select-DR. Select-DR → Capture-DR / Select-IR. Capture-DR → Shift-DR / Exit1-DR. Shift-DR → Shift-DR / Exit1-DR. Exit1-DR → Pause-DR / Update-DR. Pause-DR → Pause-DR / Exit2-DR. Exit2-DR → Shift-DR / Update-DR. Update-DR → Run-Test-Idle / Select-DR. Select-IR → Capture-IR / Test-Logic-Reset. The IR branch from Capture-IR to Update-IR mirrors the DR branch. All state-dependent actions take effect on the rising test-clock edge taken while in that state.

Top module: `jtag_ucode_tap`

## Requirements
- R1: Low `trst_n`, or five rising `tck` edges with `tms` high, puts the controller in Test-Logic-Reset. This selects the bypass instruction, and while in that state every pin follows `core_out` and `core_oe`.
- R2: The instruction register is 4 bits wide, shifted least significant bit first, and Capture-IR loads 0001. The codes, written MSB first, are bypass 1111, user code 0111, clamp 1010, high-impedance 1011, sample 0101 and external test 0000. The new code takes effect on the Update-IR edge.
- R3: Under bypass and under any code not listed in R2, the data path is one stage. It loads 0 in Capture-DR, so `tdo` returns 0 followed by `tdi` delayed by one shift.
- R4: Under user code with `cfg_done` high, Capture-DR loads the 32-bit running copy, and it shifts out least significant bit first.
- R5: Under user code with `cfg_done` low, Capture-DR loads all ones.
- R6: A pending write alone does not change what readout returns. A `ucode_reload` strobe makes the pending copy visible from the next capture. A strobe taken on the same edge as a user-code Capture-DR leaves that capture with the old running copy.
- R7: Under clamp, the data path is bypass and the pins hold the boundary update stage, with no effect from changes on `core_out` and `core_oe`.
- R8: Under high-impedance, the data path is bypass and every `pin_oe` is 0. This holds across data scans until another instruction is updated or Test-Logic-Reset is entered.
- R9: Under external test, the data path is the `2*PINS` boundary register. Bits [PINS-1:0] are pin values and bits [2*PINS-1:PINS] are pin enables, shifted bit 0 first. Update-DR copies it to the update stage, which then drives `pin_out` and `pin_oe`.
- R10: Under sample and external test, Capture-DR loads {`core_oe`, `core_out`}. Under sample, the pins stay under core control, including after Update-DR.
- R11: `tdo_oe` is 1 only while in Shift-IR or Shift-DR, and `tdo` changes only on the falling `tck` edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, updated on falling `tck` |
| tdo_oe | output | 1 | Output enable for `tdo` |
| cfg_done | input | 1 | Device configured flag; gates user-code readout |
| ucode_wr_en | input | 1 | Write strobe for the pending user code |
| ucode_wr_data | input | UCODE_W | Pending user-code value |
| ucode_reload | input | 1 | Copies the pending code into the running code |
| core_out | input | PINS | Functional output values from the core |
| core_oe | input | PINS | Functional output enables from the core |
| pin_out | output | PINS | Value presented to each user output pin |
| pin_oe | output | PINS | Drive enable for each user output pin |

## Verification
A reload strobe and a user-code Capture-DR can land on the same rising edge. In that case the identification stage must take the running copy as it was before the edge. The bench arms the strobe for exactly the step whose rising edge is the capture edge. It expects the previous code on that scan and the newly loaded code on the scan after. A second overlap is a Test-Logic-Reset entered straight from Shift-DR while high-impedance is active. The bench checks that the pins return to core control on the same edge that reaches the reset state.

// File: rtl/jtag_ucode_pkg.sv
package jtag_ucode_pkg;

    typedef enum logic [3:0] {
        ST_RESET,
        ST_IDLE,
        ST_SEL_DR,
        ST_CAP_DR,
        ST_SH_DR,
        ST_EX1_DR,
        ST_PAU_DR,
        ST_EX2_DR,
        ST_UPD_DR,
        ST_SEL_IR,
        ST_CAP_IR,
        ST_SH_IR,
        ST_EX1_IR,
        ST_PAU_IR,
        ST_EX2_IR,
        ST_UPD_IR
    } tap_state_e;

    localparam int IR_W = 4;

    localparam logic [IR_W-1:0] OP_BYPASS  = 4'b1111;
    localparam logic [IR_W-1:0] OP_UCODE   = 4'b0111;
    localparam logic [IR_W-1:0] OP_CLAMP   = 4'b1010;
    localparam logic [IR_W-1:0] OP_HIGHZ   = 4'b1011;
    localparam logic [IR_W-1:0] OP_SAMPLE  = 4'b0101;
    localparam logic [IR_W-1:0] OP_EXTEST  = 4'b0000;
    localparam logic [IR_W-1:0] IR_CAPTURE = 4'b0001;

    typedef enum logic [2:0] {
        I_BYPASS,
        I_UCODE,
        I_CLAMP,
        I_HIGHZ,
        I_SAMPLE,
        I_EXTEST
    } instr_e;

    function automatic instr_e decode_op(input logic [IR_W-1:0] op);
        case (op)
            OP_UCODE:  return I_UCODE;
            OP_CLAMP:  return I_CLAMP;
            OP_HIGHZ:  return I_HIGHZ;
            OP_SAMPLE: return I_SAMPLE;
            OP_EXTEST: return I_EXTEST;
            OP_BYPASS: return I_BYPASS;
            default:   return I_BYPASS;
        endcase
    endfunction

endpackage

// File: rtl/jtag_tap_fsm.sv
module jtag_tap_fsm
    import jtag_ucode_pkg::*;
(
    input  logic tck,
    input  logic trst_n,
    input  logic tms,
    output logic in_reset,
    output logic cap_dr,
    output logic sh_dr,
    output logic upd_dr,
    output logic cap_ir,
    output logic sh_ir,
    output logic upd_ir
);

    tap_state_e state;
    tap_state_e nxt;

    always_comb begin
        nxt = ST_RESET;
        unique case (state)
            ST_RESET:  nxt = tms ? ST_RESET  : ST_IDLE;
            ST_IDLE:   nxt = tms ? ST_SEL_DR : ST_IDLE;
            ST_SEL_DR: nxt = tms ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: nxt = tms ? ST_EX1_DR : ST_SH_DR;
            ST_SH_DR:  nxt = tms ? ST_EX1_DR : ST_SH_DR;
            ST_EX1_DR: nxt = tms ? ST_UPD_DR : ST_PAU_DR;
            ST_PAU_DR: nxt = tms ? ST_EX2_DR : ST_PAU_DR;
            ST_EX2_DR: nxt = tms ? ST_UPD_DR : ST_SH_DR;
            ST_UPD_DR: nxt = tms ? ST_SEL_DR : ST_IDLE;
            ST_SEL_IR: nxt = tms ? ST_RESET  : ST_CAP_IR;
            ST_CAP_IR: nxt = tms ? ST_EX1_IR : ST_SH_IR;
            ST_SH_IR:  nxt = tms ? ST_EX1_IR : ST_SH_IR;
            ST_EX1_IR: nxt = tms ? ST_UPD_IR : ST_PAU_IR;
            ST_PAU_IR: nxt = tms ? ST_EX2_IR : ST_PAU_IR;
            ST_EX2_IR: nxt = tms ? ST_UPD_IR : ST_SH_IR;
            ST_UPD_IR: nxt = tms ? ST_SEL_DR : ST_IDLE;
        endcase
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) state <= ST_RESET;
        else         state <= nxt;
    end

    always_comb begin
        in_reset = (state == ST_RESET);
        cap_dr   = (state == ST_CAP_DR);
        sh_dr    = (state == ST_SH_DR);
        upd_dr   = (state == ST_UPD_DR);
        cap_ir   = (state == ST_CAP_IR);
        sh_ir    = (state == ST_SH_IR);
        upd_ir   = (state == ST_UPD_IR);
    end

    // Run length of consecutive high tms samples, saturating at five.
    logic [2:0] hi_run;
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)              hi_run <= 3'd0;
        else if (!tms)            hi_run <= 3'd0;
        else if (hi_run != 3'd5)  hi_run <= hi_run + 3'd1;
    end

    a_r1_five_tms_high: assert property (@(posedge tck) disable iff (!trst_n)
        (hi_run == 3'd5) |-> (state == ST_RESET));

endmodule

// File: rtl/jtag_ucode_store.sv
module jtag_ucode_store #(
    parameter int             UW   = 32,
    parameter logic [UW-1:0]  INIT = '0
) (
    input  logic          tck,
    input  logic          trst_n,
    input  logic          cfg_done,
    input  logic          wr_en,
    input  logic [UW-1:0] wr_data,
    input  logic          reload,
    input  logic          capture,
    input  logic          shift,
    input  logic          tdi,
    output logic          so
);

    logic [UW-1:0] pending_q;
    logic [UW-1:0] running_q;
    logic [UW-1:0] id_sr;

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)    pending_q <= INIT;
        else if (wr_en) pending_q <= wr_data;
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)     running_q <= INIT;
        else if (reload) running_q <= pending_q;
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)       id_sr <= '0;
        else if (capture)  id_sr <= cfg_done ? running_q : '1;
        else if (shift)    id_sr <= {tdi, id_sr[UW-1:1]};
    end

    assign so = id_sr[0];

    a_r4_capture_running: assert property (@(posedge tck) disable iff (!trst_n)
        (capture && cfg_done) |=> (id_sr == $past(running_q)));

    a_r5_unconfigured_ones: assert property (@(posedge tck) disable iff (!trst_n)
        (capture && !cfg_done) |=> (&id_sr));

    a_r6_running_needs_reload: assert property (@(posedge tck) disable iff (!trst_n)
        !reload |=> $stable(running_q));

endmodule

// File: rtl/jtag_bscan_chain.sv
module jtag_bscan_chain #(
    parameter int PINS = 4
) (
    input  logic            tck,
    input  logic            trst_n,
    input  logic            capture,
    input  logic            shift,
    input  logic            update,
    input  logic            tdi,
    input  logic            drive_upd,
    input  logic            hiz,
    input  logic [PINS-1:0] core_out,
    input  logic [PINS-1:0] core_oe,
    output logic            so,
    output logic [PINS-1:0] pin_out,
    output logic [PINS-1:0] pin_oe
);

    localparam int BW = 2 * PINS;

    logic [BW-1:0] cap_sr;
    logic [BW-1:0] upd_q;

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)      cap_sr <= '0;
        else if (capture) cap_sr <= {core_oe, core_out};
        else if (shift)   cap_sr <= {tdi, cap_sr[BW-1:1]};
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)     upd_q <= '0;
        else if (update) upd_q <= cap_sr;
    end

    assign so = cap_sr[0];

    for (genvar p = 0; p < PINS; p++) begin : g_pin
        assign pin_out[p] = (drive_upd && !hiz) ? upd_q[p] : core_out[p];
        assign pin_oe[p]  = hiz       ? 1'b0
                          : drive_upd ? upd_q[PINS+p]
                          :             core_oe[p];
    end

    a_r9_update_only_on_strobe: assert property (@(posedge tck) disable iff (!trst_n)
        !update |=> $stable(upd_q));

endmodule

// File: rtl/jtag_ucode_tap.sv
module jtag_ucode_tap
    import jtag_ucode_pkg::*;
#(
    parameter int                  PINS       = 4,
    parameter int                  UCODE_W    = 32,
    parameter logic [UCODE_W-1:0]  UCODE_INIT = 32'h0000_0001
) (
    input  logic               tck,
    input  logic               trst_n,
    input  logic               tms,
    input  logic               tdi,
    output logic               tdo,
    output logic               tdo_oe,
    input  logic               cfg_done,
    input  logic               ucode_wr_en,
    input  logic [UCODE_W-1:0] ucode_wr_data,
    input  logic               ucode_reload,
    input  logic [PINS-1:0]    core_out,
    input  logic [PINS-1:0]    core_oe,
    output logic [PINS-1:0]    pin_out,
    output logic [PINS-1:0]    pin_oe
);

    logic in_reset, cap_dr, sh_dr, upd_dr, cap_ir, sh_ir, upd_ir;

    jtag_tap_fsm u_fsm (
        .tck      (tck),
        .trst_n   (trst_n),
        .tms      (tms),
        .in_reset (in_reset),
        .cap_dr   (cap_dr),
        .sh_dr    (sh_dr),
        .upd_dr   (upd_dr),
        .cap_ir   (cap_ir),
        .sh_ir    (sh_ir),
        .upd_ir   (upd_ir)
    );

    // Instruction shift stage and active instruction
    logic [IR_W-1:0] ir_sr;
    instr_e          instr;

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)     ir_sr <= IR_CAPTURE;
        else if (cap_ir) ir_sr <= IR_CAPTURE;
        else if (sh_ir)  ir_sr <= {tdi, ir_sr[IR_W-1:1]};
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)       instr <= I_BYPASS;
        else if (in_reset) instr <= I_BYPASS;
        else if (upd_ir)   instr <= decode_op(ir_sr);
    end

    logic sel_ucode, sel_bsr, mode_hold, mode_hiz;
    always_comb begin
        sel_ucode = (instr == I_UCODE);
        sel_bsr   = (instr == I_SAMPLE) || (instr == I_EXTEST);
        mode_hold = !in_reset && ((instr == I_EXTEST) || (instr == I_CLAMP));
        mode_hiz  = !in_reset && (instr == I_HIGHZ);
    end

    // One-stage bypass path
    logic byp_q;
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)     byp_q <= 1'b0;
        else if (cap_dr) byp_q <= 1'b0;
        else if (sh_dr)  byp_q <= tdi;
    end

    logic uc_so;
    jtag_ucode_store #(
        .UW   (UCODE_W),
        .INIT (UCODE_INIT)
    ) u_ucode (
        .tck      (tck),
        .trst_n   (trst_n),
        .cfg_done (cfg_done),
        .wr_en    (ucode_wr_en),
        .wr_data  (ucode_wr_data),
        .reload   (ucode_reload),
        .capture  (cap_dr && sel_ucode),
        .shift    (sh_dr && sel_ucode),
        .tdi      (tdi),
        .so       (uc_so)
    );

    logic bsr_so;
    jtag_bscan_chain #(
        .PINS (PINS)
    ) u_bsr (
        .tck       (tck),
        .trst_n    (trst_n),
        .capture   (cap_dr && sel_bsr),
        .shift     (sh_dr && sel_bsr),
        .update    (upd_dr && sel_bsr),
        .tdi       (tdi),
        .drive_upd (mode_hold),
        .hiz       (mode_hiz),
        .core_out  (core_out),
        .core_oe   (core_oe),
        .so        (bsr_so),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe)
    );

    // Serial output retimed to the falling edge
    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) begin
            tdo    <= 1'b0;
            tdo_oe <= 1'b0;
        end else begin
            tdo_oe <= sh_ir || sh_dr;
            if (sh_ir)                  tdo <= ir_sr[0];
            else if (sh_dr && sel_ucode) tdo <= uc_so;
            else if (sh_dr && sel_bsr)   tdo <= bsr_so;
            else if (sh_dr)              tdo <= byp_q;
            else                         tdo <= 1'b0;
        end
    end

    a_r1_reset_selects_bypass: assert property (@(posedge tck) disable iff (!trst_n)
        in_reset |=> (instr == I_BYPASS));

    a_r2_capture_ir_pattern: assert property (@(posedge tck) disable iff (!trst_n)
        cap_ir |=> (ir_sr == IR_CAPTURE));

    a_r3_bypass_captures_zero: assert property (@(posedge tck) disable iff (!trst_n)
        cap_dr |=> (byp_q == 1'b0));

    a_r7_clamp_pins_steady: assert property (@(posedge tck) disable iff (!trst_n)
        ((instr == I_CLAMP) && $past(instr == I_CLAMP) && !in_reset && !$past(in_reset))
        |-> ($stable(pin_out) && $stable(pin_oe)));

    a_r8_highz_no_drive: assert property (@(posedge tck) disable iff (!trst_n)
        ((instr == I_HIGHZ) && !in_reset) |-> (pin_oe == '0));

    a_r11_oe_only_in_shift: assert property (@(posedge tck) disable iff (!trst_n)
        tdo_oe |-> (sh_dr || sh_ir));

endmodule

// File: tb/sim_jtag_ucode_tap.sv
module sim_jtag_ucode_tap;

    localparam int          PINS = 4;
    localparam logic [31:0] INIT = 32'hA5C3_0F96;

    logic tck = 1'b0;
    always #10 tck = ~tck;

    logic            trst_n = 1'b0;
    logic            tms = 1'b1;
    logic            tdi = 1'b0;
    logic            tdo, tdo_oe;
    logic            cfg_done = 1'b1;
    logic            ucode_wr_en = 1'b0;
    logic [31:0]     ucode_wr_data = '0;
    logic            ucode_reload = 1'b0;
    logic [PINS-1:0] core_out = 4'b0101;
    logic [PINS-1:0] core_oe = 4'b0011;
    logic [PINS-1:0] pin_out, pin_oe;

    jtag_ucode_tap #(.PINS(PINS), .UCODE_W(32), .UCODE_INIT(INIT)) u0 (
        .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_oe(tdo_oe),
        .cfg_done(cfg_done), .ucode_wr_en(ucode_wr_en), .ucode_wr_data(ucode_wr_data),
        .ucode_reload(ucode_reload), .core_out(core_out), .core_oe(core_oe),
        .pin_out(pin_out), .pin_oe(pin_oe)
    );

    int   n_chk = 0;
    int   n_err = 0;
    logic rl_next = 1'b0;

    task automatic expect_eq(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One controller step: read tdo after the falling edge, drive, then rising edge.
    task automatic step(input logic m, input logic d, output logic o);
        @(negedge tck);
        #1;
        o = tdo;
        tms = m;
        tdi = d;
        ucode_reload = rl_next;
        @(posedge tck);
        #1;
        ucode_reload = 1'b0;
        rl_next = 1'b0;
    endtask

    task automatic scan_ir(input logic [3:0] code, output logic [3:0] cap);
        logic o;
        step(1'b1, 1'b0, o);
        step(1'b1, 1'b0, o);
        step(1'b0, 1'b0, o);
        step(1'b0, 1'b0, o);
        for (int i = 0; i < 4; i++) begin
            step(i == 3, code[i], o);
            cap[i] = o;
        end
        step(1'b1, 1'b0, o);
        step(1'b0, 1'b0, o);
    endtask

    task automatic scan_dr(input int len, input logic [63:0] din, input logic rl_at_cap,
                           output logic [63:0] dout);
        logic o;
        dout = '0;
        step(1'b1, 1'b0, o);
        step(1'b0, 1'b0, o);
        rl_next = rl_at_cap;
        step(1'b0, 1'b0, o);
        for (int i = 0; i < len; i++) begin
            step(i == len - 1, din[i], o);
            dout[i] = o;
        end
        step(1'b1, 1'b0, o);
        step(1'b0, 1'b0, o);
    endtask

    task automatic write_pending(input logic [31:0] v);
        @(negedge tck);
        #1;
        ucode_wr_en = 1'b1;
        ucode_wr_data = v;
        @(posedge tck);
        #1;
        ucode_wr_en = 1'b0;
    endtask

    task automatic check_bypass(input string req, input logic [7:0] pat);
        logic [63:0] got;
        scan_dr(8, {56'd0, pat}, 1'b0, got);
        expect_eq(req, got, {56'd0, pat[6:0], 1'b0});
    endtask

    task automatic t_reset();
        logic o;
        logic [3:0] cap;
        expect_eq("R1 pin_out after trst", {60'd0, pin_out}, {60'd0, core_out});
        expect_eq("R1 pin_oe after trst", {60'd0, pin_oe}, {60'd0, core_oe});
        expect_eq("R11 tdo_oe idle", {63'd0, tdo_oe}, 64'd0);
        step(1'b0, 1'b0, o);
        check_bypass("R1 bypass selected by reset", 8'h5B);
        scan_ir(4'b0011, cap);
        expect_eq("R2 capture-IR pattern", {60'd0, cap}, 64'd1);
        check_bypass("R3 unlisted code acts as bypass", 8'hC5);
    endtask

    task automatic t_tdo_timing();
        logic o;
        logic [3:0] cap;
        scan_ir(4'b1111, cap);
        step(1'b1, 1'b0, o);
        step(1'b0, 1'b0, o);
        step(1'b0, 1'b0, o);
        step(1'b0, 1'b1, o);
        expect_eq("R3 bypass captured zero", {63'd0, o}, 64'd0);
        expect_eq("R11 tdo_oe in shift", {63'd0, tdo_oe}, 64'd1);
        expect_eq("R11 tdo held after rising edge", {63'd0, tdo}, 64'd0);
        @(negedge tck);
        #1;
        expect_eq("R11 tdo moves on falling edge", {63'd0, tdo}, 64'd1);
        step(1'b1, 1'b0, o);
        step(1'b1, 1'b0, o);
        step(1'b0, 1'b0, o);
        @(negedge tck);
        #1;
        expect_eq("R11 tdo_oe off after shift", {63'd0, tdo_oe}, 64'd0);
    endtask

    task automatic t_usercode();
        logic [63:0] got;
        logic [3:0]  cap;
        cfg_done = 1'b1;
        scan_ir(4'b0111, cap);
        scan_dr(32, 64'd0, 1'b0, got);
        expect_eq("R4 running code readout", got, {32'd0, INIT});
        cfg_done = 1'b0;
        scan_dr(32, 64'd0, 1'b0, got);
        expect_eq("R5 unconfigured reads ones", got, 64'h0000_0000_FFFF_FFFF);
        cfg_done = 1'b1;
    endtask

    task automatic t_pending();
        logic [63:0] got;
        logic o;
        write_pending(32'h0BAD_F00D);
        scan_dr(32, 64'd0, 1'b0, got);
        expect_eq("R6 pending hidden before reload", got, {32'd0, INIT});
        rl_next = 1'b1;
        step(1'b0, 1'b0, o);
        scan_dr(32, 64'd0, 1'b0, got);
        expect_eq("R6 pending visible after reload", got, 64'h0BAD_F00D);
        write_pending(32'hCAFE_1234);
        scan_dr(32, 64'd0, 1'b1, got);
        expect_eq("R6 reload on capture edge keeps old", got, 64'h0BAD_F00D);
        scan_dr(32, 64'd0, 1'b0, got);
        expect_eq("R6 reload seen on next capture", got, 64'hCAFE_1234);
    endtask

    task automatic t_extest();
        logic [63:0] got;
        logic [3:0]  cap;
        core_out = 4'b0011;
        core_oe  = 4'b1100;
        scan_ir(4'b0000, cap);
        scan_dr(8, 64'hA6, 1'b0, got);
        expect_eq("R10 extest capture of core", got, 64'hC3);
        expect_eq("R9 pin_out from update stage", {60'd0, pin_out}, 64'h6);
        expect_eq("R9 pin_oe from update stage", {60'd0, pin_oe}, 64'hA);
    endtask

    task automatic t_clamp();
        logic [3:0] cap;
        scan_ir(4'b1010, cap);
        core_out = 4'b1111;
        core_oe  = 4'b1111;
        #1;
        expect_eq("R7 clamp holds pin_out", {60'd0, pin_out}, 64'h6);
        expect_eq("R7 clamp holds pin_oe", {60'd0, pin_oe}, 64'hA);
        check_bypass("R7 clamp path is bypass", 8'h3C);
        expect_eq("R7 pins unchanged by scan", {56'd0, pin_oe, pin_out}, 64'hA6);
    endtask

    task automatic t_highz_sample();
        logic [63:0] got;
        logic [3:0]  cap;
        scan_ir(4'b1011, cap);
        expect_eq("R8 highz disables drive", {60'd0, pin_oe}, 64'd0);
        check_bypass("R8 highz path is bypass", 8'h81);
        expect_eq("R8 highz persists across scan", {60'd0, pin_oe}, 64'd0);
        core_out = 4'b1001;
        core_oe  = 4'b0110;
        scan_ir(4'b0101, cap);
        expect_eq("R8 released by new instruction", {60'd0, pin_oe}, 64'h6);
        scan_dr(8, 64'hFF, 1'b0, got);
        expect_eq("R10 sample capture of core", got, 64'h69);
        expect_eq("R10 sample keeps core values", {56'd0, pin_oe, pin_out}, 64'h69);
    endtask

    task automatic t_tms_reset();
        logic o;
        logic [3:0] cap;
        scan_ir(4'b1011, cap);
        expect_eq("R8 highz before tms reset", {60'd0, pin_oe}, 64'd0);
        step(1'b1, 1'b0, o);
        step(1'b0, 1'b0, o);
        step(1'b0, 1'b0, o);
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0, o);
        expect_eq("R1 five tms high releases pin_oe", {60'd0, pin_oe}, {60'd0, core_oe});
        expect_eq("R1 five tms high releases pin_out", {60'd0, pin_out}, {60'd0, core_out});
        step(1'b0, 1'b0, o);
        check_bypass("R1 bypass after tms reset", 8'h96);
    endtask

    initial begin
        #45;
        trst_n = 1'b1;
        t_reset();
        t_tdo_timing();
        t_usercode();
        t_pending();
        t_extest();
        t_clamp();
        t_highz_sample();
        t_tms_reset();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        #(20 * 100000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule